// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block works out the address of the next instruction for a machine whose instructions are each one 16-bit word. It gets the current PC and a decoded control-transfer type each cycle, and it drives the next PC and a taken flag. The next PC comes from one of five sources, chosen by the transfer type:

- the sequential address;
- a conditional PC-relative branch with a 9-bit offset;
- an unconditional PC-relative jump with an 11-bit offset;
- an absolute call whose target is aligned to 16 words;
- a register-indirect jump, used for returns and dynamic calls.

The block also holds the condition-code register. The unit asserts a compare enable on a compare instruction, and the condition-code register then takes the signed ordering of two operands. A later conditional branch selects one or more of the stored codes through a three-bit mask and is taken when any selected code is set. The next-PC path is fully combinational. The only state is the condition-code register, which is written on the rising clock edge. A branch in the cycle after a compare therefore sees the new codes.

Top module: `pc_next_unit`

## Requirements
- R1: Transfer codes on `xfer_i` are: 0 sequential, 1 branch, 2 jump, 3 call, 4 indirect. Codes 5 to 7 behave as sequential. For a sequential transfer, `pc_next_o` = `pc_i` + 1 modulo 2^16 and `taken_o` = 0.
- R2: A taken branch gives `pc_next_o` = `pc_i` + 1 + sign-extended `imm_i[8:0]`, modulo 2^16. Bits `imm_i[10:9]` have no effect on a branch.
- R3: A branch that is not taken gives `pc_next_o` = `pc_i` + 1 and `taken_o` = 0.
- R4: The condition codes and `cond_mask_i` use the same bit order: bit 2 negative, bit 1 zero, bit 0 positive. A branch is taken exactly when (`cond_mask_i` & codes) is nonzero, and `taken_o` is then 1.
- R5: On a rising edge with `cmp_en_i` high, the codes become exactly one of: negative if `cmp_a_i` < `cmp_b_i`, zero if they are equal, positive if `cmp_a_i` > `cmp_b_i`. The operands are compared as signed 16-bit values, and a branch in the next cycle sees the new codes.
- R6: While `cmp_en_i` is low, the codes hold their value whatever the operands are.
- R7: After reset, all condition codes are 0, so no branch is taken with any mask until a compare has been done.
- R8: A jump gives `pc_next_o` = `pc_i` + 1 + sign-extended `imm_i[10:0]`, modulo 2^16.
- R9: A call gives `pc_next_o` = {`pc_i[15]`, `imm_i[10:0]`, 4'b0000}.
- R10: An indirect transfer gives `pc_next_o` = `reg_i`.
- R11: `taken_o` is 1 for jump, call and indirect transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 16 | Current PC |
| xfer_i | input | 3 | Decoded transfer type |
| imm_i | input | 11 | Offset or absolute-target field |
| reg_i | input | 16 | Register value for indirect transfers |
| cond_mask_i | input | 3 | Branch mask {n,z,p} |
| cmp_en_i | input | 1 | Compare enable; updates codes on the edge |
| cmp_a_i | input | 16 | First compare operand |
| cmp_b_i | input | 16 | Second compare operand |
| pc_next_o | output | 16 | Next PC |
| taken_o | output | 1 | Control transfer taken |

## Verification
Jump and call targets are swept over every value of the 11-bit field, at PCs near zero, at the sign boundary and at the top of memory. These sweeps separate sign extension from zero extension and show that modulo wrap and the kept PC top bit are correct. Compares are run over a grid of operand pairs that straddle zero and the extremes of the signed range. This grid separates a signed compare from an unsigned one. After each compare, all eight branch masks are applied, which separates the AND rule from an equality or priority rule. Separate sequences show that the codes are held while compare enable is low, that branches are never taken after reset, and that the two upper immediate bits are ignored on branches.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    XFER_SEQ  = 3'd0,
    XFER_BR   = 3'd1,
    XFER_JMP  = 3'd2,
    XFER_CALL = 3'd3,
    XFER_IND  = 3'd4
  } xfer_e;

  localparam int unsigned CC_W = 3;
  localparam int unsigned CC_N = 2;
  localparam int unsigned CC_Z = 1;
  localparam int unsigned CC_P = 0;
endpackage

// File: rtl/npc_cc_reg.sv
module npc_cc_reg #(
  parameter int unsigned XLEN = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmp_en_i,
  input  logic [XLEN-1:0]          cmp_a_i,
  input  logic [XLEN-1:0]          cmp_b_i,
  output logic [npc_pkg::CC_W-1:0] cc_o
);
  import npc_pkg::*;

  logic [CC_W-1:0] cc_d, cc_q;

  always_comb begin
    cc_d = '0;
    if ($signed(cmp_a_i) < $signed(cmp_b_i))      cc_d[CC_N] = 1'b1;
    else if (cmp_a_i == cmp_b_i)                  cc_d[CC_Z] = 1'b1;
    else                                          cc_d[CC_P] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cc_q <= '0;
    else if (cmp_en_i) cc_q <= cc_d;
  end

  assign cc_o = cc_q;

  p_cc_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i |=> $countones(cc_o) == 1);
  p_cc_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && $signed(cmp_a_i) < $signed(cmp_b_i)) |=> cc_o[CC_N]);
  p_cc_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> $stable(cc_o));
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval (
  input  logic [npc_pkg::CC_W-1:0] cc_i,
  input  logic [npc_pkg::CC_W-1:0] mask_i,
  output logic                     hit_o
);
  assign hit_o = |(cc_i & mask_i);
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int unsigned XLEN       = 16,
  parameter int unsigned IMM_W      = 11,
  parameter int unsigned BR_OFF_W   = 9,
  parameter int unsigned JMP_OFF_W  = 11,
  parameter int unsigned CALL_W     = 11,
  parameter int unsigned CALL_SHIFT = 4
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o,
  output logic [XLEN-1:0]  call_o
);
  localparam int unsigned CALL_HI = CALL_W + CALL_SHIFT;

  logic [XLEN-1:0] br_off, jmp_off;

  assign br_off  = {{(XLEN-BR_OFF_W){imm_i[BR_OFF_W-1]}}, imm_i[BR_OFF_W-1:0]};
  assign jmp_off = {{(XLEN-JMP_OFF_W){imm_i[JMP_OFF_W-1]}}, imm_i[JMP_OFF_W-1:0]};

  assign seq_o = pc_i + XLEN'(1);
  assign br_o  = seq_o + br_off;
  assign jmp_o = seq_o + jmp_off;

  // call target keeps the PC bits above the absolute field
  generate
    if (CALL_HI < XLEN) begin : g_call_keep_top
      assign call_o = {pc_i[XLEN-1:CALL_HI], imm_i[CALL_W-1:0], {CALL_SHIFT{1'b0}}};
    end else begin : g_call_full
      assign call_o = {imm_i[CALL_W-1:0], {CALL_SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int unsigned XLEN       = 16,
  parameter int unsigned BR_OFF_W   = 9,
  parameter int unsigned JMP_OFF_W  = 11,
  parameter int unsigned CALL_W     = 11,
  parameter int unsigned CALL_SHIFT = 4,
  parameter int unsigned IMM_W      = (JMP_OFF_W > CALL_W) ? JMP_OFF_W : CALL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [2:0]       xfer_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  reg_i,
  input  logic [2:0]       cond_mask_i,
  input  logic             cmp_en_i,
  input  logic [XLEN-1:0]  cmp_a_i,
  input  logic [XLEN-1:0]  cmp_b_i,
  output logic [XLEN-1:0]  pc_next_o,
  output logic             taken_o
);
  import npc_pkg::*;

  logic [CC_W-1:0] cc;
  logic            cond_hit;
  logic [XLEN-1:0] seq_tgt, br_tgt, jmp_tgt, call_tgt;

  npc_cc_reg #(.XLEN(XLEN)) u_cc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_en_i (cmp_en_i),
    .cmp_a_i  (cmp_a_i),
    .cmp_b_i  (cmp_b_i),
    .cc_o     (cc)
  );

  npc_cond_eval u_cond (
    .cc_i   (cc),
    .mask_i (cond_mask_i),
    .hit_o  (cond_hit)
  );

  npc_target_gen #(
    .XLEN(XLEN), .IMM_W(IMM_W), .BR_OFF_W(BR_OFF_W),
    .JMP_OFF_W(JMP_OFF_W), .CALL_W(CALL_W), .CALL_SHIFT(CALL_SHIFT)
  ) u_tgt (
    .pc_i   (pc_i),
    .imm_i  (imm_i),
    .seq_o  (seq_tgt),
    .br_o   (br_tgt),
    .jmp_o  (jmp_tgt),
    .call_o (call_tgt)
  );

  always_comb begin
    pc_next_o = seq_tgt;
    taken_o   = 1'b0;
    case (xfer_i)
      XFER_BR: if (cond_hit) begin
        pc_next_o = br_tgt;
        taken_o   = 1'b1;
      end
      XFER_JMP:  begin pc_next_o = jmp_tgt;  taken_o = 1'b1; end
      XFER_CALL: begin pc_next_o = call_tgt; taken_o = 1'b1; end
      XFER_IND:  begin pc_next_o = reg_i;    taken_o = 1'b1; end
      default: ;
    endcase
  end

  p_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == XFER_SEQ) |-> (pc_next_o == pc_i + XLEN'(1)) && !taken_o);
  p_br_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == XFER_BR && cond_mask_i == '0) |-> !taken_o && (pc_next_o == pc_i + XLEN'(1)));
  p_call_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == XFER_CALL) |-> pc_next_o[CALL_SHIFT-1:0] == '0);
  p_ind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == XFER_IND) |-> (pc_next_o == reg_i) && taken_o);
  p_reset_cc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && xfer_i == XFER_BR) |-> !taken_o);
endmodule

// File: tb/tb_pc_next_unit.sv
module tb_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic [2:0]  xfer = '0;
  logic [10:0] imm = '0;
  logic [15:0] rv = '0;
  logic [2:0]  mask = '0;
  logic        cmp_en = 1'b0;
  logic [15:0] ca = '0, cb = '0;
  logic [15:0] pc_next;
  logic        taken;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pc_next_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .xfer_i(xfer), .imm_i(imm),
    .reg_i(rv), .cond_mask_i(mask), .cmp_en_i(cmp_en), .cmp_a_i(ca),
    .cmp_b_i(cb), .pc_next_o(pc_next), .taken_o(taken)
  );

  task automatic check(input string req, input logic [15:0] exp_pc, input logic exp_tk);
    #1;
    n_chk++;
    if (pc_next !== exp_pc || taken !== exp_tk) begin
      n_fail++;
      $display("FAIL %s: pc_next=%h taken=%b expected pc_next=%h taken=%b (pc=%h xfer=%0d imm=%h mask=%b)",
               req, pc_next, taken, exp_pc, exp_tk, pc, xfer, imm, mask);
    end
  endtask

  task automatic do_cmp(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    cmp_en = 1'b1; ca = a; cb = b;
    @(negedge clk);
    cmp_en = 1'b0;
  endtask

  function automatic logic [2:0] exp_cc(input logic [15:0] a, input logic [15:0] b);
    if ($signed(a) < $signed(b)) return 3'b100;
    if (a == b) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic [15:0] sx9(input logic [10:0] v);
    return {{7{v[8]}}, v[8:0]};
  endfunction

  function automatic logic [15:0] sx11(input logic [10:0] v);
    return {{5{v[10]}}, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ops [8];
    logic [15:0] pcs [4];
    ops = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005, 16'hFFFB, 16'h7FFE};
    pcs = '{16'h0000, 16'h7FF8, 16'h8000, 16'hFFF0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: codes zero after reset, every mask misses
    xfer = 3'd1; pc = 16'h1234; imm = 11'h0FF;
    for (int m = 0; m < 8; m++) begin
      mask = m[2:0];
      check("R7", 16'h1235, 1'b0);
    end

    // R1: sequential and unused codes
    for (int p = 0; p < 65536; p += 509) begin
      pc = p[15:0];
      xfer = 3'd0; check("R1", pc + 16'd1, 1'b0);
      xfer = 3'd5; check("R1", pc + 16'd1, 1'b0);
      xfer = 3'd7; check("R1", pc + 16'd1, 1'b0);
    end
    pc = 16'hFFFF; xfer = 3'd6; check("R1", 16'h0000, 1'b0);

    // R4 R5 R2 R3: signed compare grid, all masks
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [2:0] cc;
        do_cmp(ops[i], ops[j]);
        cc = exp_cc(ops[i], ops[j]);
        xfer = 3'd1; pc = 16'h4000 + 16'(i * 8 + j); imm = 11'(i * 97 + j * 31);
        for (int m = 0; m < 8; m++) begin
          mask = m[2:0];
          if ((mask & cc) != 0) check("R4/R5/R2", pc + 16'd1 + sx9(imm), 1'b1);
          else                  check("R4/R5/R3", pc + 16'd1, 1'b0);
        end
      end
    end

    // R6: hold while compare disabled
    do_cmp(16'd5, 16'd3);
    @(negedge clk);
    ca = 16'hFFFF; cb = 16'd3;
    repeat (2) @(negedge clk);
    ca = 16'd7; cb = 16'd7;
    @(negedge clk);
    xfer = 3'd1; pc = 16'h0100; imm = 11'h010;
    mask = 3'b001; check("R6", 16'h0111, 1'b1);
    mask = 3'b110; check("R6", 16'h0101, 1'b0);

    // R2: branch offset sweep, upper imm bits ignored
    do_cmp(16'd0, 16'd0);
    xfer = 3'd1; mask = 3'b010;
    for (int k = 0; k < 2048; k += 7) begin
      for (int q = 0; q < 4; q++) begin
        pc = pcs[q]; imm = k[10:0];
        check("R2", pcs[q] + 16'd1 + sx9(imm), 1'b1);
      end
    end

    // R8 R11: jump sweep
    xfer = 3'd2;
    for (int k = 0; k < 2048; k++) begin
      for (int q = 0; q < 4; q += 3) begin
        pc = pcs[q]; imm = k[10:0];
        check("R8/R11", pcs[q] + 16'd1 + sx11(imm), 1'b1);
      end
    end

    // R9 R11: call sweep
    xfer = 3'd3;
    for (int k = 0; k < 2048; k++) begin
      for (int q = 0; q < 4; q += 2) begin
        pc = pcs[q] | 16'h000F; imm = k[10:0];
        check("R9/R11", {pc[15], imm, 4'b0000}, 1'b1);
      end
    end

    // R10 R11: indirect
    xfer = 3'd4; pc = 16'h2222;
    for (int v = 0; v < 65536; v += 1021) begin
      rv = v[15:0];
      check("R10/R11", rv, 1'b1);
    end
    rv = 16'hFFFF; check("R10/R11", 16'hFFFF, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule